// File: doc/BRIEF.md
# Transceiver Power-Up and Reset Sequencer

This block times the power-up and re-lock of a single serial transceiver lane. A one-microsecond strobe, derived from the reference clock, paces every window. Once the supply is declared good, the lane stays in its reset window for 40 µs. The sequencer then releases, one after another, the PLL from its minimum-frequency hold, the receiver analog circuits, the receiver data-lock loop and finally the data-valid / comma-enable flag.

A device reset, a sleep request or PLL bypass keeps the sequence parked. Raising any of them partway through throws it back to time zero, so waking from sleep always costs the full lock-in. After startup, the receiver can be told to stop tracking data. While it is stopped, its parallel output is frozen. When tracking is re-enabled, data is reported locked again after a short 2 µs re-lock.

All outputs are decoded from registered state. Each output changes on the clock edge that follows the edge where the causing input or strobe was sampled.

Top module: `xcvr_pwrup_seq`

## Requirements
- R1: While `supply_ok` is low, and for 40 strobes of `tick_us` after it goes high, `ser_force_low`, `rx_out_hold` and `pll_hold_min` are 1 and every other output is 0; device reset, sleep and bypass requests do not shorten this window.
- R2: The startup sequence advances only while `dev_rst_n` is 1 and `sleep_req` and `pll_bypass` are 0; while bypass alone is requested, only `pll_hold_min` is 1.
- R3: During the first 32 strobes of the startup sequence `pll_hold_min` is 1 and `rx_analog_en`, `rx_data_lock_en` and `data_valid` are 0.
- R4: From strobe 32 of the sequence `pll_hold_min` is 0 and `rx_analog_en` is 1, and both stay so while the lane remains up.
- R5: From strobe 262 of the sequence `rx_data_lock_en` is 1.
- R6: From strobe 358 of the sequence `data_valid` is 1; it is never 1 before that.
- R7: Once `data_valid` is up, `rx_track_en` = 0 drops `rx_data_lock_en` and `data_valid` and sets `rx_out_hold`. When `rx_track_en` returns to 1, `data_valid` rises on the second following strobe. `rx_track_en` has no effect before the sequence first reaches `data_valid`.
- R8: `dev_rst_n` = 0 sets `ser_force_low`, `rx_out_hold` and `pll_hold_min` and clears the other outputs.
- R9: `sleep_req` = 1 sets `pll_power_down` and `pll_hold_min` and clears the other outputs; on wake the full 358-strobe sequence runs again.
- R10: A device reset, sleep or bypass request at any point after the reset window restarts the sequence from strobe zero once the request clears. When requests coincide, reset wins over sleep and sleep wins over bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_ok | input | 1 | Supply good; low resets the sequencer synchronously |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| dev_rst_n | input | 1 | Device reset request, active low |
| sleep_req | input | 1 | Low-power sleep request |
| pll_bypass | input | 1 | PLL bypass request |
| rx_track_en | input | 1 | 1 = receiver tracks data, 0 = receiver idles |
| pll_hold_min | output | 1 | Hold PLL at minimum frequency |
| pll_power_down | output | 1 | PLL powered down (sleep) |
| rx_analog_en | output | 1 | Receiver analog circuits enabled |
| rx_data_lock_en | output | 1 | Receiver data-lock loop enabled |
| data_valid | output | 1 | Parallel data valid, comma detection enabled |
| ser_force_low | output | 1 | Force serial output to logic 0 |
| rx_out_hold | output | 1 | Freeze receive parallel output |

## Verification
The lane is first brought up from a clean supply. It is probed one strobe before and one strobe after each of the 40, 32, 262 and 358 boundaries, which separates an off-by-one in any window from a correct one.

The tracking control is toggled twice, once after data is valid and once during PLL lock, so the bench sees both its effect and its absence. A sleep, a device reset and a bypass are each raised at a different phase and then released. The run then checks that every one of them forces a restart from zero rather than a resume. A cycle-accurate behavioural model is compared on every clock and catches any stray output between the probes.

// File: rtl/xcvr_pwrup_pkg.sv
package xcvr_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_HOLD     = 4'd0,
        ST_RESET    = 4'd1,
        ST_SLEEP    = 4'd2,
        ST_BYPASS   = 4'd3,
        ST_START    = 4'd4,
        ST_PLLACQ   = 4'd5,
        ST_DATAACQ  = 4'd6,
        ST_RUN      = 4'd7,
        ST_IDLEREF  = 4'd8,
        ST_RELOCK   = 4'd9
    } seq_state_e;

    typedef struct packed {
        logic pll_hold_min;
        logic pll_power_down;
        logic rx_analog_en;
        logic rx_data_lock_en;
        logic data_valid;
        logic ser_force_low;
        logic rx_out_hold;
    } seq_ctrl_t;

    // Priority among parking requests: reset, then sleep, then bypass.
    function automatic seq_state_e park_cause(input logic rst_n,
                                              input logic sleep,
                                              input logic bypass);
        seq_state_e c;
        c = ST_BYPASS;
        if (!rst_n)      c = ST_RESET;
        else if (sleep)  c = ST_SLEEP;
        else if (bypass) c = ST_BYPASS;
        return c;
    endfunction

    function automatic seq_ctrl_t ctrl_of(input seq_state_e s);
        seq_ctrl_t o;
        o = '0;
        unique case (s)
            ST_HOLD, ST_RESET: begin
                o.pll_hold_min  = 1'b1;
                o.ser_force_low = 1'b1;
                o.rx_out_hold   = 1'b1;
            end
            ST_SLEEP: begin
                o.pll_hold_min   = 1'b1;
                o.pll_power_down = 1'b1;
            end
            ST_BYPASS, ST_START: o.pll_hold_min = 1'b1;
            ST_PLLACQ: o.rx_analog_en = 1'b1;
            ST_DATAACQ, ST_RELOCK: begin
                o.rx_analog_en    = 1'b1;
                o.rx_data_lock_en = 1'b1;
            end
            ST_RUN: begin
                o.rx_analog_en    = 1'b1;
                o.rx_data_lock_en = 1'b1;
                o.data_valid      = 1'b1;
            end
            ST_IDLEREF: begin
                o.rx_analog_en = 1'b1;
                o.rx_out_hold  = 1'b1;
            end
            default: o.pll_hold_min = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/xcvr_pwrup_timer.sv
module xcvr_pwrup_timer #(
    parameter int MAX_COUNT = 400
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             tick,
    output logic [$clog2(MAX_COUNT+1)-1:0]   count
);
    localparam int CW = $clog2(MAX_COUNT + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_COUNT);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (tick && count != TOP)
            count <= count + 1'b1;
    end

    // R10
    timer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && count != TOP) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/xcvr_pwrup_fsm.sv
module xcvr_pwrup_fsm
    import xcvr_pwrup_pkg::*;
#(
    parameter int HOLD_US       = 40,
    parameter int PLL_MIN_US    = 32,
    parameter int DLOCK_US      = 262,
    parameter int VALID_US      = 358,
    parameter int RELOCK_US     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       dev_rst_n,
    input  logic       sleep_req,
    input  logic       pll_bypass,
    input  logic       rx_track_en,
    output seq_state_e state
);
    localparam int CNT_MAX = (HOLD_US > VALID_US) ? HOLD_US : VALID_US;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LIM_HOLD   = CW'(HOLD_US - 1);
    localparam logic [CW-1:0] LIM_PLL    = CW'(PLL_MIN_US - 1);
    localparam logic [CW-1:0] LIM_DLOCK  = CW'(DLOCK_US - 1);
    localparam logic [CW-1:0] LIM_VALID  = CW'(VALID_US - 1);
    localparam logic [CW-1:0] LIM_RELOCK = CW'(RELOCK_US - 1);

    seq_state_e      state_q, state_d;
    logic            clr;
    logic [CW-1:0]   cnt;
    logic            parked_req;
    seq_state_e      cause;

    assign parked_req = !dev_rst_n || sleep_req || pll_bypass;
    assign cause      = park_cause(dev_rst_n, sleep_req, pll_bypass);

    xcvr_pwrup_timer #(.MAX_COUNT(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .tick  (tick),
        .count (cnt)
    );

    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        if (state_q == ST_HOLD) begin
            if (tick && cnt == LIM_HOLD) begin
                state_d = parked_req ? cause : ST_START;
                clr     = 1'b1;
            end
        end else if (parked_req) begin
            state_d = cause;
            clr     = 1'b1;
        end else begin
            unique case (state_q)
                ST_RESET, ST_SLEEP, ST_BYPASS: begin
                    state_d = ST_START;
                    clr     = 1'b1;
                end
                ST_START:   if (tick && cnt == LIM_PLL)   state_d = ST_PLLACQ;
                ST_PLLACQ:  if (tick && cnt == LIM_DLOCK) state_d = ST_DATAACQ;
                ST_DATAACQ: if (tick && cnt == LIM_VALID) state_d = ST_RUN;
                ST_RUN:     if (!rx_track_en)             state_d = ST_IDLEREF;
                ST_IDLEREF: if (rx_track_en) begin
                    state_d = ST_RELOCK;
                    clr     = 1'b1;
                end
                ST_RELOCK: begin
                    if (!rx_track_en)
                        state_d = ST_IDLEREF;
                    else if (tick && cnt == LIM_RELOCK)
                        state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_START;
                    clr     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R10
    park_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (parked_req && state_q != ST_HOLD) |=> state_q == $past(cause));

    // R7
    idle_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !rx_track_en && !parked_req) |=> state_q == ST_IDLEREF);

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN)
            |-> ($past(state_q) == ST_DATAACQ || $past(state_q) == ST_RELOCK));

endmodule

// File: rtl/xcvr_pwrup_decode.sv
module xcvr_pwrup_decode
    import xcvr_pwrup_pkg::*;
(
    input  seq_state_e state,
    output seq_ctrl_t  ctrl
);
    always_comb ctrl = ctrl_of(state);
endmodule

// File: rtl/xcvr_pwrup_seq.sv
module xcvr_pwrup_seq
    import xcvr_pwrup_pkg::*;
#(
    parameter int HOLD_US    = 40,
    parameter int PLL_MIN_US = 32,
    parameter int DLOCK_US   = 262,
    parameter int VALID_US   = 358,
    parameter int RELOCK_US  = 2
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic tick_us,
    input  logic dev_rst_n,
    input  logic sleep_req,
    input  logic pll_bypass,
    input  logic rx_track_en,
    output logic pll_hold_min,
    output logic pll_power_down,
    output logic rx_analog_en,
    output logic rx_data_lock_en,
    output logic data_valid,
    output logic ser_force_low,
    output logic rx_out_hold
);
    logic       rst;
    seq_state_e state;
    seq_ctrl_t  ctrl;

    assign rst = !supply_ok;

    xcvr_pwrup_fsm #(
        .HOLD_US    (HOLD_US),
        .PLL_MIN_US (PLL_MIN_US),
        .DLOCK_US   (DLOCK_US),
        .VALID_US   (VALID_US),
        .RELOCK_US  (RELOCK_US)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_us),
        .dev_rst_n   (dev_rst_n),
        .sleep_req   (sleep_req),
        .pll_bypass  (pll_bypass),
        .rx_track_en (rx_track_en),
        .state       (state)
    );

    xcvr_pwrup_decode u_dec (
        .state (state),
        .ctrl  (ctrl)
    );

    assign pll_hold_min    = ctrl.pll_hold_min;
    assign pll_power_down  = ctrl.pll_power_down;
    assign rx_analog_en    = ctrl.rx_analog_en;
    assign rx_data_lock_en = ctrl.rx_data_lock_en;
    assign data_valid      = ctrl.data_valid;
    assign ser_force_low   = ctrl.ser_force_low;
    assign rx_out_hold     = ctrl.rx_out_hold;

    // R8
    reset_force_chk: assert property (@(posedge clk) disable iff (rst)
        !dev_rst_n |=> (ser_force_low && rx_out_hold && pll_hold_min));

    // R9
    sleep_pd_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && dev_rst_n && !ser_force_low) |=> (pll_power_down && !rx_analog_en));

    // R6
    valid_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(rx_data_lock_en));

endmodule

// File: tb/tb_xcvr_pwrup_seq.sv
module tb_xcvr_pwrup_seq;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic supply_ok = 1'b0, tick_us = 1'b0, dev_rst_n = 1'b1;
    logic sleep_req = 1'b0, pll_bypass = 1'b0, rx_track_en = 1'b1;
    logic pll_hold_min, pll_power_down, rx_analog_en, rx_data_lock_en;
    logic data_valid, ser_force_low, rx_out_hold;

    int tests = 0, fails = 0;

    xcvr_pwrup_seq dut (
        .clk(clk), .supply_ok(supply_ok), .tick_us(tick_us),
        .dev_rst_n(dev_rst_n), .sleep_req(sleep_req), .pll_bypass(pll_bypass),
        .rx_track_en(rx_track_en), .pll_hold_min(pll_hold_min),
        .pll_power_down(pll_power_down), .rx_analog_en(rx_analog_en),
        .rx_data_lock_en(rx_data_lock_en), .data_valid(data_valid),
        .ser_force_low(ser_force_low), .rx_out_hold(rx_out_hold)
    );

    // Behavioural model: phase name plus elapsed microseconds.
    localparam int M_HOLD = 0, M_RST = 1, M_SLP = 2, M_BYP = 3, M_SEQ = 4,
                   M_RUN = 5, M_IDLE = 6, M_RELOCK = 7;
    int  m_ph = M_HOLD;
    int  m_us = 0;
    bit  m_live = 0;

    always @(posedge clk) begin
        bit park;
        int why;
        park = !dev_rst_n || sleep_req || pll_bypass;
        why  = !dev_rst_n ? M_RST : (sleep_req ? M_SLP : M_BYP);
        if (!supply_ok) begin
            m_ph = M_HOLD; m_us = 0;
        end else if (m_ph == M_HOLD) begin
            if (tick_us) m_us++;
            if (m_us == 40) begin m_ph = park ? why : M_SEQ; m_us = 0; end
        end else if (park) begin
            m_ph = why; m_us = 0;
        end else begin
            case (m_ph)
                M_RST, M_SLP, M_BYP: begin m_ph = M_SEQ; m_us = 0; end
                M_SEQ: begin
                    if (tick_us) m_us++;
                    if (m_us >= 358) m_ph = M_RUN;
                end
                M_RUN:  if (!rx_track_en) m_ph = M_IDLE;
                M_IDLE: if (rx_track_en) begin m_ph = M_RELOCK; m_us = 0; end
                M_RELOCK: begin
                    if (!rx_track_en) m_ph = M_IDLE;
                    else begin
                        if (tick_us) m_us++;
                        if (m_us == 2) m_ph = M_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    // expected {hold_min, pwr_dn, ana, dlock, valid, force_low, rx_hold}
    function automatic logic [6:0] model_out();
        case (m_ph)
            M_HOLD, M_RST: return 7'b1000011;
            M_SLP:         return 7'b1100000;
            M_BYP:         return 7'b1000000;
            M_SEQ: begin
                if (m_us < 32)       return 7'b1000000;
                else if (m_us < 262) return 7'b0010000;
                else                 return 7'b0011000;
            end
            M_RUN:    return 7'b0011100;
            M_IDLE:   return 7'b0010001;
            M_RELOCK: return 7'b0011000;
            default:  return 7'b0000000;
        endcase
    endfunction

    always @(negedge clk) begin
        logic [6:0] got, exp;
        if (m_live) begin
            got = {pll_hold_min, pll_power_down, rx_analog_en, rx_data_lock_en,
                   data_valid, ser_force_low, rx_out_hold};
            exp = model_out();
            tests++;
            if (got !== exp) begin
                fails++;
                $display("FAIL model R3/R4/R5/R6/R7/R8/R9 outputs at %0t: got %b expected %b",
                         $time, got, exp);
            end
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic step_us(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_us = 1'b1;
            @(negedge clk) tick_us = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        m_live = 1;
        // R1 supply low
        chk("R1 force_low in supply reset", ser_force_low, 1'b1);
        chk("R1 rx_hold in supply reset", rx_out_hold, 1'b1);
        chk("R1 valid low in supply reset", data_valid, 1'b0);
        supply_ok = 1'b1;
        sleep_req = 1'b1;
        step_us(20);
        chk("R1 sleep ignored in hold window", pll_power_down, 1'b0);
        sleep_req = 1'b0;
        step_us(19);
        chk("R1 still held at 39", ser_force_low, 1'b1);
        step_us(1);
        chk("R1 released at 40", ser_force_low, 1'b0);
        chk("R3 pll held at start", pll_hold_min, 1'b1);
        step_us(31);
        chk("R3 pll held at 31", pll_hold_min, 1'b1);
        chk("R3 analog off at 31", rx_analog_en, 1'b0);
        step_us(1);
        chk("R4 pll released at 32", pll_hold_min, 1'b0);
        chk("R4 analog on at 32", rx_analog_en, 1'b1);
        step_us(229);
        chk("R5 data lock off at 261", rx_data_lock_en, 1'b0);
        step_us(1);
        chk("R5 data lock on at 262", rx_data_lock_en, 1'b1);
        step_us(95);
        chk("R6 not valid at 357", data_valid, 1'b0);
        step_us(1);
        chk("R6 valid at 358", data_valid, 1'b1);

        rx_track_en = 1'b0;
        step_us(3);
        chk("R7 idle drops valid", data_valid, 1'b0);
        chk("R7 idle drops data lock", rx_data_lock_en, 1'b0);
        chk("R7 idle holds rx output", rx_out_hold, 1'b1);
        rx_track_en = 1'b1;
        step_us(1);
        chk("R7 not valid 1us after relock", data_valid, 1'b0);
        step_us(1);
        chk("R7 valid 2us after relock", data_valid, 1'b1);

        dev_rst_n = 1'b0;
        step_us(2);
        chk("R8 reset forces serial low", ser_force_low, 1'b1);
        chk("R8 reset holds rx output", rx_out_hold, 1'b1);
        chk("R8 reset holds pll", pll_hold_min, 1'b1);
        dev_rst_n = 1'b1;
        step_us(100);
        rx_track_en = 1'b0;
        step_us(5);
        chk("R7 track ignored during startup (hold)", rx_out_hold, 1'b0);
        chk("R7 track ignored during startup (analog)", rx_analog_en, 1'b1);
        rx_track_en = 1'b1;
        step_us(252);
        chk("R10 restart after reset not valid at 357", data_valid, 1'b0);
        step_us(1);
        chk("R10 restart after reset valid at 358", data_valid, 1'b1);

        sleep_req = 1'b1;
        step_us(2);
        chk("R9 sleep powers down pll", pll_power_down, 1'b1);
        chk("R9 sleep disables analog", rx_analog_en, 1'b0);
        sleep_req = 1'b0;
        step_us(357);
        chk("R9 wake not valid at 357", data_valid, 1'b0);
        step_us(1);
        chk("R9 wake valid at 358", data_valid, 1'b1);

        dev_rst_n = 1'b0;
        step_us(1);
        dev_rst_n = 1'b1;
        step_us(200);
        pll_bypass = 1'b1;
        sleep_req  = 1'b1;
        step_us(1);
        chk("R10 sleep wins over bypass", pll_power_down, 1'b1);
        sleep_req = 1'b0;
        step_us(1);
        chk("R2 bypass holds pll", pll_hold_min, 1'b1);
        chk("R2 bypass analog off", rx_analog_en, 1'b0);
        chk("R2 bypass no force low", ser_force_low, 1'b0);
        step_us(40);
        chk("R2 bypass parks sequence", rx_analog_en, 1'b0);
        pll_bypass = 1'b0;
        step_us(31);
        chk("R10 restart from zero at 31", pll_hold_min, 1'b1);
        step_us(1);
        chk("R10 analog at 32 after restart", rx_analog_en, 1'b1);

        supply_ok = 1'b0;
        step_us(1);
        chk("R1 supply drop forces low", ser_force_low, 1'b1);
        chk("R1 supply drop clears analog", rx_analog_en, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule